// File: doc/BRIEF.md
# Quadrature Position Counter with Compare Match

The block tracks shaft position from an incremental encoder. Two phase inputs are decoded at four counts per electrical cycle into a 16-bit up/down count. A third input is an index (zero-mark) line. The three inputs arrive asynchronously. Each passes through a two-flop synchronizer, and all decoding and edge detection work on the synchronized values.

Two compare registers are checked against the count. Each one produces its own one-cycle match pulse. Software-style write ports set the compare values and a 10-bit control word.

The counter can return to zero from three independent sources:
- a match on a selected compare register
- a chosen edge of the index input
- a programmed level pattern across all three inputs

On underflow the counter either wraps or reloads from compare register 0.

Top module: `qenc_poscnt`

## Requirements
- R1: After reset the count is 0, both match pulses are low, the control word and both compare registers are 0, and the synchronized inputs are taken as low.
- R2: With run (control bit 0) set, the phases are decoded at 4x. In terms of {A,B}, the sequence 00→10→11→01→00 adds 1 per transition, and the reverse sequence subtracts 1.
- R3: A transition in which A and B change in the same synchronized sample does not change the count.
- R4: While run is 0 the count holds, whatever happens on any input. Phase transitions made while stopped are not counted later.
- R5: match_o[i] is high for one cycle, in the cycle after the count changed to a value equal to compare register i. A count that stays equal, or a compare write equal to the held count, gives no pulse.
- R6: When control bit 1 (register 0) or bit 2 (register 1) is set, a match pulse on that register clears the count to 0 at the next clock edge.
- R7: Control bits 4:3 select the index edge that clears the count: 00 none, 01 rising, 10 falling, 11 both.
- R8: When control bit 5 is set, the count is cleared on every cycle in which the synchronized {Z,B,A} equals control bits 8:6.
- R9: A down step from 0 gives FFFFh when control bit 9 is 0, and gives the value of compare register 0 when bit 9 is 1. An up step from FFFFh gives 0.
- R10: Any clear takes priority over a count step or a reload in the same cycle.
- R11: An input change driven between edges changes the count at the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_z | input | 1 | Encoder index input, asynchronous |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 10 | Control word: [0] run, [1] clear on match 0, [2] clear on match 1, [4:3] index edge select, [5] level clear enable, [8:6] level pattern {Z,B,A}, [9] reload on underflow |
| cmp_we | input | 2 | Per-register write strobes for the compare registers |
| cmp_wdata | input | 16 | Compare write data |
| count_o | output | 16 | Current count |
| match_o | output | 2 | One-cycle compare match pulses |

## Verification
The assertions check the following on every cycle:
- the count is frozen while stopped
- every match pulse coincides with a count change
- any active clear forces zero on the next edge
- wrap and reload values at underflow
- single-step increments

The following depend on the bench scenarios, which compare against a behavioural reference model cycle by cycle:
- the decode direction and the rejection of double-phase transitions
- the three-edge input latency
- each index edge selection
- the level pattern
- the suppression of pulses for held or rewritten equal values

// File: rtl/qenc_pkg.sv
package qenc_pkg;

   typedef enum logic [1:0] {
      ZSEL_OFF  = 2'b00,
      ZSEL_RISE = 2'b01,
      ZSEL_FALL = 2'b10,
      ZSEL_BOTH = 2'b11
   } zsel_e;

   // bit 9 down to bit 0
   typedef struct packed {
      logic       reload;
      logic       lvl_z;
      logic       lvl_b;
      logic       lvl_a;
      logic       lvl_en;
      zsel_e      zsel;
      logic [1:0] clr_mt;
      logic       run;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw_i,
   output logic [N-1:0] sync_o,
   output logic [N-1:0] prev_o
);
   logic [N-1:0] meta_q;
   logic [N-1:0] sync_q;
   logic [N-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         sync_q <= '0;
         prev_q <= '0;
      end else begin
         meta_q <= raw_i;
         sync_q <= meta_q;
         prev_q <= sync_q;
      end
   end

   assign sync_o = sync_q;
   assign prev_o = prev_q;
endmodule

// File: rtl/qenc_quad.sv
module qenc_quad (
   input  logic [1:0] cur_i,
   input  logic [1:0] prv_i,
   output logic       up_o,
   output logic       dn_o
);
   logic single;
   logic fwd;

   always_comb begin
      single = (cur_i[0] ^ prv_i[0]) ^ (cur_i[1] ^ prv_i[1]);
      fwd    = cur_i[0] ^ prv_i[1];
      up_o   = single & fwd;
      dn_o   = single & ~fwd;
   end
endmodule

// File: rtl/qenc_match.sv
module qenc_match #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cnt_q_i,
   input  logic [W-1:0] cnt_d_i,
   input  logic [W-1:0] ref_i,
   output logic         hit_o
);
   logic hit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= (cnt_d_i != cnt_q_i) && (cnt_d_i == ref_i);
   end

   assign hit_o = hit_q;
endmodule

// File: rtl/qenc_poscnt.sv
module qenc_poscnt
   import qenc_pkg::*;
#(
   parameter int W    = 16,
   parameter int NCMP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enc_a,
   input  logic              enc_b,
   input  logic              enc_z,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic [NCMP-1:0]   cmp_we,
   input  logic [W-1:0]      cmp_wdata,
   output logic [W-1:0]      count_o,
   output logic [NCMP-1:0]   match_o
);
   localparam int NIN = 3;
   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

   generate
      if (W < 2) begin : g_bad_w
         $error("qenc_poscnt: W must be at least 2");
      end
      if (NCMP != 2) begin : g_bad_ncmp
         $error("qenc_poscnt: NCMP must be 2 to match the control word");
      end
   endgenerate

   ctrl_t          ctrl_q;
   logic [W-1:0]   cnt_q;
   logic [W-1:0]   cnt_d;
   logic [W-1:0]   cmp_q [NCMP];
   logic [NIN-1:0] s_zba;
   logic [NIN-1:0] p_zba;
   logic           step_up;
   logic           step_dn;
   logic           z_hit;
   logic           lvl_hit;
   logic           mt_hit;
   logic           clr_any;

   // signals brought out for the bound checker
   logic           run_w;
   logic           reload_w;
   logic [W-1:0]   cmp0_w;

   qenc_sync #(.N(NIN)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i ({enc_z, enc_b, enc_a}),
      .sync_o(s_zba),
      .prev_o(p_zba)
   );

   qenc_quad u_quad (
      .cur_i(s_zba[1:0]),
      .prv_i(p_zba[1:0]),
      .up_o (step_up),
      .dn_o (step_dn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wdata);
   end

   genvar gi;
   generate
      for (gi = 0; gi < NCMP; gi++) begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cmp_q[gi] <= '0;
            else if (cmp_we[gi]) cmp_q[gi] <= cmp_wdata;
         end

         qenc_match #(.W(W)) u_match (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt_q_i(cnt_q),
            .cnt_d_i(cnt_d),
            .ref_i  (cmp_q[gi]),
            .hit_o  (match_o[gi])
         );
      end
   endgenerate

   always_comb begin
      unique case (ctrl_q.zsel)
         ZSEL_RISE: z_hit = s_zba[2] & ~p_zba[2];
         ZSEL_FALL: z_hit = ~s_zba[2] & p_zba[2];
         ZSEL_BOTH: z_hit = s_zba[2] ^ p_zba[2];
         default:   z_hit = 1'b0;
      endcase
      lvl_hit = ctrl_q.lvl_en &&
                (s_zba == {ctrl_q.lvl_z, ctrl_q.lvl_b, ctrl_q.lvl_a});
      mt_hit  = |(match_o & ctrl_q.clr_mt);
      clr_any = z_hit | lvl_hit | mt_hit;
   end

   always_comb begin
      cnt_d = cnt_q;
      if (ctrl_q.run) begin
         if (clr_any)
            cnt_d = '0;
         else if (step_up)
            cnt_d = cnt_q + 1'b1;
         else if (step_dn)
            cnt_d = (cnt_q == '0) ? (ctrl_q.reload ? cmp_q[0] : ALL_ONES)
                                  : cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign count_o  = cnt_q;
   assign run_w    = ctrl_q.run;
   assign reload_w = ctrl_q.reload;
   assign cmp0_w   = cmp_q[0];
endmodule

// File: rtl/qenc_poscnt_chk.sv
module qenc_poscnt_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         run,
   input logic         reload,
   input logic         clr_any,
   input logic         up,
   input logic         dn,
   input logic [W-1:0] count,
   input logic [W-1:0] cmp0,
   input logic [1:0]   match
);
   // R4
   assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(count));

   // R5
   assert_match0_on_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
      match[0] |-> (count != $past(count)));

   // R5
   assert_match1_on_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
      match[1] |-> (count != $past(count)));

   // R10
   assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && clr_any) |=> (count == '0));

   // R9
   assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr_any && dn && count == '0 && reload) |=> (count == $past(cmp0)));

   // R9
   assert_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr_any && dn && count == '0 && !reload) |=> (count == {W{1'b1}}));

   // R2
   assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr_any && up) |=> (count == $past(count) + 1'b1));
endmodule

bind qenc_poscnt qenc_poscnt_chk #(.W(W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .run    (run_w),
   .reload (reload_w),
   .clr_any(clr_any),
   .up     (step_up),
   .dn     (step_dn),
   .count  (count_o),
   .cmp0   (cmp0_w),
   .match  (match_o)
);

// File: tb/qenc_poscnt_tb_top.sv
`timescale 1ns/1ps
module qenc_poscnt_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ea = 1'b0, eb = 1'b0, ez = 1'b0;
   logic        ctrl_we = 1'b0;
   logic [9:0]  ctrl_wdata = '0;
   logic [1:0]  cmp_we = '0;
   logic [15:0] cmp_wdata = '0;
   logic [15:0] count_o;
   logic [1:0]  match_o;

   int total = 0;
   int bad = 0;
   bit done = 0;
   int qs = 0;
   int pulses0 = 0;
   string cur_req = "R1";

   localparam bit [9:0] RUN = 10'h001;

   always #2 clk = ~clk;

   qenc_poscnt dut_i (
      .clk(clk), .rst_n(rst_n), .enc_a(ea), .enc_b(eb), .enc_z(ez),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
      .count_o(count_o), .match_o(match_o)
   );

   // reference model
   bit [2:0] m_s1, m_s2, m_p;
   int       m_cnt;
   bit [1:0] m_match;
   int       m_cmp [2];
   bit [9:0] m_ctrl;
   int       md, mnxt;
   bit       mclr, mz;

   function automatic int gidx(bit a, bit b);
      case ({a, b})
         2'b00:   return 0;
         2'b10:   return 1;
         2'b11:   return 2;
         default: return 3;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_p = 0; m_cnt = 0; m_match = 0;
         m_cmp[0] = 0; m_cmp[1] = 0; m_ctrl = 0;
      end else begin
         md = (gidx(m_s2[0], m_s2[1]) - gidx(m_p[0], m_p[1]) + 4) % 4;
         case (m_ctrl[4:3])
            2'd1:    mz = m_s2[2] && !m_p[2];
            2'd2:    mz = !m_s2[2] && m_p[2];
            2'd3:    mz = m_s2[2] != m_p[2];
            default: mz = 0;
         endcase
         mclr = mz || (m_ctrl[5] && m_s2 == m_ctrl[8:6]) ||
                (m_match[0] && m_ctrl[1]) || (m_match[1] && m_ctrl[2]);
         mnxt = m_cnt;
         if (m_ctrl[0]) begin
            if (mclr) mnxt = 0;
            else if (md == 1) mnxt = (m_cnt + 1) % 65536;
            else if (md == 3) mnxt = (m_cnt == 0) ? (m_ctrl[9] ? m_cmp[0] : 65535) : m_cnt - 1;
         end
         for (int i = 0; i < 2; i++) m_match[i] = (mnxt != m_cnt) && (mnxt == m_cmp[i]);
         m_p = m_s2; m_s2 = m_s1; m_s1 = {ez, eb, ea};
         m_cnt = mnxt;
         if (ctrl_we) m_ctrl = ctrl_wdata;
         for (int i = 0; i < 2; i++) if (cmp_we[i]) m_cmp[i] = cmp_wdata;
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         total++;
         if (int'(count_o) != m_cnt || match_o != m_match) begin
            bad++;
            $display("FAIL %s cycle compare: count=%h match=%b expected count=%h match=%b",
                     cur_req, count_o, match_o, m_cnt[15:0], m_match);
         end
         if (match_o[0]) pulses0++;
      end
   end

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_ctrl(bit [9:0] v);
      @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
      @(negedge clk); ctrl_we = 0;
   endtask

   task automatic set_cmp(int i, int v);
      @(negedge clk); cmp_we = 2'b00; cmp_we[i] = 1'b1; cmp_wdata = v[15:0];
      @(negedge clk); cmp_we = 2'b00;
   endtask

   task automatic drive_q();
      case (qs)
         0: begin ea = 0; eb = 0; end
         1: begin ea = 1; eb = 0; end
         2: begin ea = 1; eb = 1; end
         default: begin ea = 0; eb = 1; end
      endcase
   endtask

   task automatic quad(bit up, int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         qs = up ? (qs + 1) % 4 : (qs + 3) % 4;
         drive_q();
         idle(1);
      end
   endtask

   initial begin
      idle(3);
      rst_n = 1;
      @(negedge clk);
      cur_req = "R1";
      chk("R1 count after reset", count_o, 0);
      chk("R1 match after reset", match_o, 0);

      cur_req = "R2";
      set_ctrl(RUN);
      quad(1, 5); idle(4);
      chk("R2 five up steps", count_o, 5);
      quad(0, 2); idle(4);
      chk("R2 two down steps", count_o, 3);

      cur_req = "R11";
      @(negedge clk); qs = (qs + 1) % 4; drive_q();
      @(negedge clk); chk("R11 after edge 1", count_o, 3);
      @(negedge clk); chk("R11 after edge 2", count_o, 3);
      @(negedge clk); chk("R11 after edge 3", count_o, 4);

      cur_req = "R3";
      @(negedge clk); qs = (qs + 2) % 4; drive_q();
      idle(5);
      chk("R3 double change ignored", count_o, 4);
      quad(1, 1); idle(4);
      chk("R3 decode resumes", count_o, 5);

      cur_req = "R4";
      set_ctrl(10'h000);
      quad(1, 3); idle(4);
      chk("R4 stopped holds", count_o, 5);
      set_ctrl(RUN); idle(4);
      chk("R4 no late steps", count_o, 5);
      quad(1, 1); idle(4);
      chk("R4 counting again", count_o, 6);

      cur_req = "R5";
      set_cmp(0, 8);
      pulses0 = 0;
      quad(1, 2); idle(20);
      chk("R5 count reached", count_o, 8);
      chk("R5 single pulse", pulses0, 1);
      set_cmp(0, 8); idle(5);
      chk("R5 no pulse on equal rewrite", pulses0, 1);

      cur_req = "R6";
      set_cmp(1, 10);
      set_ctrl(RUN | 10'h004);
      quad(1, 2); idle(6);
      chk("R6 clear on match 1", count_o, 0);
      set_ctrl(RUN);

      cur_req = "R7";
      quad(1, 3); idle(4);
      set_ctrl(RUN | (10'd1 << 3));
      @(negedge clk); ez = 1; idle(5);
      chk("R7 rising edge clear", count_o, 0);
      quad(1, 2); idle(4);
      set_ctrl(RUN | (10'd2 << 3));
      @(negedge clk); ez = 0; idle(5);
      chk("R7 falling edge clear", count_o, 0);
      quad(1, 2); idle(4);
      @(negedge clk); ez = 1; idle(5);
      chk("R7 rise ignored in falling mode", count_o, 2);
      set_ctrl(RUN);
      @(negedge clk); ez = 0; idle(4);

      cur_req = "R8";
      quad(1, 1); idle(4);
      set_ctrl(RUN | 10'h020 | (10'd7 << 6));
      @(negedge clk); ez = 1;
      while (qs != 2) quad(1, 1);
      idle(6);
      chk("R8 level pattern holds zero", count_o, 0);
      quad(1, 1); idle(4);
      chk("R8 counts after pattern left", count_o, 1);
      set_ctrl(RUN);
      @(negedge clk); ez = 0; idle(4);

      cur_req = "R9";
      quad(0, 1); idle(4);
      chk("R9 down to zero", count_o, 0);
      quad(0, 1); idle(4);
      chk("R9 wrap to FFFF", count_o, 16'hFFFF);
      quad(1, 1); idle(4);
      chk("R9 wrap up to zero", count_o, 0);
      set_cmp(0, 16'h1234);
      set_ctrl(RUN | 10'h200);
      quad(0, 1); idle(4);
      chk("R9 reload from cmp0", count_o, 16'h1234);

      cur_req = "R10";
      set_ctrl(RUN | (10'd1 << 3));
      @(negedge clk); ez = 1; qs = (qs + 1) % 4; drive_q();
      idle(5);
      chk("R10 clear beats step", count_o, 0);

      idle(4);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule